// File: doc/BRIEF.md
# Axis Interrupt Collector

This block gathers the interrupt sources of one axis of a pulse-train motion controller and drives one active-low interrupt request line. It keeps three summary flags: a stop flag, an error flag and an event flag. A nine-bit error cause register and a fourteen-bit event cause register sit behind the error and event flags. A thirteen-bit event enable register picks which event causes are recorded. The motion core sends each cause as a one-cycle pulse.

The host works through three paths. The first is a 32-bit data buffer, which the host can write directly. The second is a command strobe with an 8-bit opcode. Opcode F2h copies the error causes into the buffer. Opcode F3h copies the event causes into the buffer. Opcode ACh loads the event enables from the buffer. The third is a status read strobe, which clears the stop flag. Two mode words carry the stop-interrupt enable and the output mask. Reading a cause register clears all of its bits in one step. A cause that arrives in the same cycle as that read survives for the next read.

Top module: `axis_irq_collector`

## Requirements
- R1: After reset the cause registers, the event enables, the flags, the mask, the stop enable and the buffer are all 0, and `irq_n` is 1.
- R2: A pulse on `err_pulse[i]` sets error cause bit i and the error flag (status bit 4) at the next clock edge. The bit assignment is: 0 +limit stop, 1 -limit stop, 2 alarm stop, 3 stop-input stop, 4 emergency stop, 5 slow-down stop, 6 pulser counter overflow stop, 7 encoder input error, 8 pulser input error.
- R3: Command F2h loads the buffer with the error causes in bits [8:0], with zeros above. At the same edge it clears the error causes and the error flag, except for causes pulsed in that same cycle, which stay set.
- R4: Event cause bit c is recorded, and the event flag (status bit 5) set, only when its enable bit is 1. Causes 0 to 10 use enable bit c. Causes 11 and 12 (+ and - direction change) both use enable bit 11. Cause 13 (stop-select input) uses enable bit 12.
- R5: Command F3h loads the buffer with the event causes in bits [13:0], with zeros above. It clears the event causes and the event flag in the same way as R3.
- R6: Command ACh loads the event enables from buffer bits [12:0].
- R7: The stop flag (status bit 2) sets on `stop_pulse` only while the stop enable is 1. The stop enable is bit 30 of mode word 2. A status read clears the stop flag, unless a qualifying stop arrives in that same cycle.
- R8: `irq_n` is 0 exactly when at least one flag is set and the mask is 0. The mask is bit 29 of mode word 1. While the mask is 1, `irq_n` stays 1 and the flags still latch.
- R9: Only bits 2, 4 and 5 of `stat_byte` can ever be 1.
- R10: `buf_wr` loads the buffer from `buf_wdata`. A copy command in the same cycle takes priority over `buf_wr`. Any other opcode changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_pulse | input | 9 | One-cycle error cause pulses |
| evt_pulse | input | 14 | One-cycle event cause pulses |
| stop_pulse | input | 1 | One-cycle pulse when the axis stops |
| mode1_wr | input | 1 | Write strobe for mode word 1 |
| mode1_data | input | 32 | Mode word 1; bit 29 is the output mask |
| mode2_wr | input | 1 | Write strobe for mode word 2 |
| mode2_data | input | 32 | Mode word 2; bit 30 is the stop-interrupt enable |
| buf_wr | input | 1 | Host write strobe for the buffer |
| buf_wdata | input | 32 | Host buffer data |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| stat_rd | input | 1 | Status read strobe |
| stat_byte | output | 8 | Status byte: stop, error and event flags |
| buf_rdata | output | 32 | Buffer contents |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A cause pulse driven in one cycle shows up on `stat_byte` and `irq_n` right after the next rising edge. A command or buffer write shows up on `buf_rdata` one edge later. The stop flag clears one edge after a status read. The bench changes its inputs on falling edges, holds them for exactly one cycle, and samples results at the following falling edge, so each check lands half a period after the edge that updated the result. The sweeps cover every error bit, and every pairing of a single enable bit with a single event cause, with the expected buffer values computed from the enable mapping.

// File: rtl/axis_irq_pkg.sv
package axis_irq_pkg;
    parameter int ERR_W   = 9;
    parameter int EVT_W   = 14;
    parameter int EN_W    = 13;
    parameter int DATA_W  = 32;
    parameter int MASK_BIT    = 29;
    parameter int STOP_EN_BIT = 30;
    parameter int ST_STOP_BIT = 2;
    parameter int ST_ERR_BIT  = 4;
    parameter int ST_EVT_BIT  = 5;
    parameter int DIR_PLUS    = 11;
    parameter int DIR_MINUS   = 12;

    parameter logic [7:0] OP_COPY_ERR = 8'hF2;
    parameter logic [7:0] OP_COPY_EVT = 8'hF3;
    parameter logic [7:0] OP_LOAD_EN  = 8'hAC;

    // Enable bit that gates a given event cause: the two direction-change
    // causes share one enable, and later causes shift down by one.
    function automatic int en_index(input int cause);
        if (cause < DIR_PLUS)
            return cause;
        else if (cause <= DIR_MINUS)
            return DIR_PLUS;
        else
            return cause - 1;
    endfunction

    typedef struct packed {
        logic [EN_W-1:0]   en;
        logic              mask;
        logic              stop_en;
        logic              f_stop;
        logic [DATA_W-1:0] buffer;
    } ctl_state_t;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] cause_o,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] cause;
        logic         flag;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr_i) begin
            bank_d.cause = set_i;
            bank_d.flag  = |set_i;
        end else begin
            bank_d.cause = bank_q.cause | set_i;
            bank_d.flag  = bank_q.flag | (|set_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign cause_o = bank_q.cause;
    assign flag_o  = bank_q.flag;
endmodule

// File: rtl/evt_enable_gate.sv
module evt_enable_gate
    import axis_irq_pkg::*;
(
    input  logic [EVT_W-1:0] raw_i,
    input  logic [EN_W-1:0]  en_i,
    output logic [EVT_W-1:0] gated_o
);
    for (genvar c = 0; c < EVT_W; c++) begin : g_cause
        localparam int EI = en_index(c);
        assign gated_o[c] = raw_i[c] & en_i[EI];
    end
endmodule

// File: rtl/axis_irq_collector.sv
module axis_irq_collector
    import axis_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ERR_W-1:0]  err_pulse,
    input  logic [EVT_W-1:0]  evt_pulse,
    input  logic              stop_pulse,
    input  logic              mode1_wr,
    input  logic [DATA_W-1:0] mode1_data,
    input  logic              mode2_wr,
    input  logic [DATA_W-1:0] mode2_data,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              cmd_vld,
    input  logic [7:0]        cmd_op,
    input  logic              stat_rd,
    output logic [7:0]        stat_byte,
    output logic [DATA_W-1:0] buf_rdata,
    output logic              irq_n
);
    localparam int ERR_PAD = DATA_W - ERR_W;
    localparam int EVT_PAD = DATA_W - EVT_W;

    ctl_state_t st_d, st_q;

    logic             rd_err, rd_evt, ld_en;
    logic [ERR_W-1:0] err_cause;
    logic [EVT_W-1:0] evt_cause;
    logic [EVT_W-1:0] evt_gated;
    logic             f_err, f_evt;
    logic             stop_hit;
    logic             stop_en_w, mask_w;
    logic             unused_bits;

    assign rd_err = cmd_vld && (cmd_op == OP_COPY_ERR);
    assign rd_evt = cmd_vld && (cmd_op == OP_COPY_EVT);
    assign ld_en  = cmd_vld && (cmd_op == OP_LOAD_EN);

    irq_cause_bank #(.W(ERR_W)) err_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (err_pulse),
        .clr_i   (rd_err),
        .cause_o (err_cause),
        .flag_o  (f_err)
    );

    evt_enable_gate evt_gate_i (
        .raw_i   (evt_pulse),
        .en_i    (st_q.en),
        .gated_o (evt_gated)
    );

    irq_cause_bank #(.W(EVT_W)) evt_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_gated),
        .clr_i   (rd_evt),
        .cause_o (evt_cause),
        .flag_o  (f_evt)
    );

    assign stop_hit = stop_pulse && st_q.stop_en;

    always_comb begin
        st_d = st_q;
        if (mode1_wr)
            st_d.mask = mode1_data[MASK_BIT];
        if (mode2_wr)
            st_d.stop_en = mode2_data[STOP_EN_BIT];
        if (stat_rd)
            st_d.f_stop = stop_hit;
        else
            st_d.f_stop = st_q.f_stop | stop_hit;
        if (ld_en)
            st_d.en = st_q.buffer[EN_W-1:0];
        if (rd_err)
            st_d.buffer = {{ERR_PAD{1'b0}}, err_cause};
        else if (rd_evt)
            st_d.buffer = {{EVT_PAD{1'b0}}, evt_cause};
        else if (buf_wr)
            st_d.buffer = buf_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        stat_byte = '0;
        stat_byte[ST_STOP_BIT] = st_q.f_stop;
        stat_byte[ST_ERR_BIT]  = f_err;
        stat_byte[ST_EVT_BIT]  = f_evt;
    end

    assign buf_rdata = st_q.buffer;
    assign irq_n     = ~((st_q.f_stop | f_err | f_evt) & ~st_q.mask);

    assign stop_en_w = st_q.stop_en;
    assign mask_w    = st_q.mask;

    assign unused_bits = ^{mode1_data[DATA_W-1:MASK_BIT+1], mode1_data[MASK_BIT-1:0],
                           mode2_data[DATA_W-1:STOP_EN_BIT+1], mode2_data[STOP_EN_BIT-1:0]};
endmodule

// File: rtl/axis_irq_chk.sv
module axis_irq_chk
    import axis_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ERR_W-1:0]  err_pulse,
    input logic              stop_pulse,
    input logic              stop_en,
    input logic              mask,
    input logic              cmd_vld,
    input logic [7:0]        cmd_op,
    input logic [ERR_W-1:0]  err_cause,
    input logic [7:0]        stat_byte,
    input logic [DATA_W-1:0] buf_rdata,
    input logic              irq_n
);
    // R2: any error pulse leaves the error flag set
    p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_pulse) |=> stat_byte[ST_ERR_BIT]);

    // R3: a read with no new cause empties the error side
    p_err_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == OP_COPY_ERR && err_pulse == '0)
        |=> (!stat_byte[ST_ERR_BIT] && err_cause == '0));

    // R3: the buffer receives the causes present before the read
    p_err_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == OP_COPY_ERR)
        |=> buf_rdata == {{(DATA_W-ERR_W){1'b0}}, $past(err_cause)});

    // R7: the stop flag only rises after a qualifying stop
    p_stop_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_byte[ST_STOP_BIT]) |-> $past(stop_pulse && stop_en));

    // R8: a masked output never asserts
    p_mask_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> irq_n);

    // R8: an unmasked pending flag drives the request
    p_req_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask && stat_byte != 8'h00) |-> !irq_n);
endmodule

bind axis_irq_collector axis_irq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_pulse  (err_pulse),
    .stop_pulse (stop_pulse),
    .stop_en    (stop_en_w),
    .mask       (mask_w),
    .cmd_vld    (cmd_vld),
    .cmd_op     (cmd_op),
    .err_cause  (err_cause),
    .stat_byte  (stat_byte),
    .buf_rdata  (buf_rdata),
    .irq_n      (irq_n)
);

// File: tb/axis_irq_collector_tb.sv
module axis_irq_collector_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  err_pulse = '0;
    logic [13:0] evt_pulse = '0;
    logic        stop_pulse = 1'b0;
    logic        mode1_wr = 1'b0;
    logic [31:0] mode1_data = '0;
    logic        mode2_wr = 1'b0;
    logic [31:0] mode2_data = '0;
    logic        buf_wr = 1'b0;
    logic [31:0] buf_wdata = '0;
    logic        cmd_vld = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic        stat_rd = 1'b0;
    logic [7:0]  stat_byte;
    logic [31:0] buf_rdata;
    logic        irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axis_irq_collector dut_i (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .evt_pulse(evt_pulse),
        .stop_pulse(stop_pulse), .mode1_wr(mode1_wr), .mode1_data(mode1_data),
        .mode2_wr(mode2_wr), .mode2_data(mode2_data), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .stat_rd(stat_rd), .stat_byte(stat_byte), .buf_rdata(buf_rdata),
        .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        cmd_vld = 1'b1; cmd_op = op; tick(); cmd_vld = 1'b0; cmd_op = '0;
    endtask

    task automatic load_buf(input logic [31:0] v);
        buf_wr = 1'b1; buf_wdata = v; tick(); buf_wr = 1'b0;
    endtask

    task automatic set_mode1(input logic [31:0] v);
        mode1_wr = 1'b1; mode1_data = v; tick(); mode1_wr = 1'b0;
    endtask

    task automatic set_mode2(input logic [31:0] v);
        mode2_wr = 1'b1; mode2_data = v; tick(); mode2_wr = 1'b0;
    endtask

    function automatic int en_of(input int c);
        if (c <= 10) return c;
        if (c <= 12) return 11;
        return 12;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check(stat_byte == 8'h00, "R1 status", {24'b0, stat_byte}, 0);
        check(buf_rdata == 0, "R1 buffer", buf_rdata, 0);
        check(irq_n == 1'b1, "R1 irq_n", {31'b0, irq_n}, 1);
        cmd(8'hF2);
        check(buf_rdata == 0, "R1 error causes", buf_rdata, 0);
        cmd(8'hF3);
        check(buf_rdata == 0, "R1 event causes", buf_rdata, 0);

        // R2/R3: each error bit on its own
        for (int i = 0; i < 9; i++) begin
            err_pulse = 9'(1 << i); tick(); err_pulse = '0;
            check(stat_byte == 8'h10, "R2 error flag", {24'b0, stat_byte}, 32'h10);
            check(irq_n == 1'b0, "R8 irq on error", {31'b0, irq_n}, 0);
            cmd(8'hF2);
            check(buf_rdata == (32'h1 << i), "R2 error bit position", buf_rdata, 32'h1 << i);
            check(stat_byte == 8'h00, "R3 error flag cleared", {24'b0, stat_byte}, 0);
        end

        // R3: accumulation and same-cycle arrival during a read
        err_pulse = 9'h041; tick();
        err_pulse = 9'h100; tick();
        err_pulse = 9'h008; cmd_vld = 1'b1; cmd_op = 8'hF2; tick();
        err_pulse = '0; cmd_vld = 1'b0;
        check(buf_rdata == 32'h141, "R3 accumulated copy", buf_rdata, 32'h141);
        check(stat_byte == 8'h10, "R3 same-cycle cause kept", {24'b0, stat_byte}, 32'h10);
        cmd(8'hF2);
        check(buf_rdata == 32'h008, "R3 kept cause reread", buf_rdata, 32'h008);

        // R4/R5/R6: every single enable against every single cause
        for (int e = 0; e < 13; e++) begin
            load_buf(32'h1 << e);
            cmd(8'hAC);
            for (int c = 0; c < 14; c++) begin
                logic [31:0] exp;
                exp = (en_of(c) == e) ? (32'h1 << c) : 32'h0;
                evt_pulse = 14'(1 << c); tick(); evt_pulse = '0;
                check(stat_byte[5] == (exp != 0), "R4 event flag vs enable",
                      {24'b0, stat_byte}, (exp != 0) ? 32'h20 : 32'h0);
                cmd(8'hF3);
                check(buf_rdata == exp, "R5 event copy", buf_rdata, exp);
                check(stat_byte == 8'h00, "R5 event flag cleared", {24'b0, stat_byte}, 0);
            end
        end

        // R6: full enable, all causes at once
        load_buf(32'hFFFF_FFFF);
        cmd(8'hAC);
        evt_pulse = 14'h3FFF; tick(); evt_pulse = '0;
        cmd(8'hF3);
        check(buf_rdata == 32'h3FFF, "R6 full enable copy", buf_rdata, 32'h3FFF);
        // R5: same-cycle event during read is kept
        evt_pulse = 14'h0004; tick();
        evt_pulse = 14'h2000; cmd_vld = 1'b1; cmd_op = 8'hF3; tick();
        evt_pulse = '0; cmd_vld = 1'b0;
        check(buf_rdata == 32'h0004, "R5 copy before arrival", buf_rdata, 32'h4);
        cmd(8'hF3);
        check(buf_rdata == 32'h2000, "R5 kept event reread", buf_rdata, 32'h2000);

        // R7: stop flag gated by enable
        stop_pulse = 1'b1; tick(); stop_pulse = 1'b0;
        check(stat_byte == 8'h00, "R7 stop without enable", {24'b0, stat_byte}, 0);
        set_mode2(32'h4000_0000);
        stop_pulse = 1'b1; tick(); stop_pulse = 1'b0;
        check(stat_byte == 8'h04, "R7 stop flag set", {24'b0, stat_byte}, 4);
        stat_rd = 1'b1; stop_pulse = 1'b1; tick(); stat_rd = 1'b0; stop_pulse = 1'b0;
        check(stat_byte == 8'h04, "R7 same-cycle stop kept", {24'b0, stat_byte}, 4);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        check(stat_byte == 8'h00, "R7 status read clears", {24'b0, stat_byte}, 0);
        check(irq_n == 1'b1, "R8 idle irq_n", {31'b0, irq_n}, 1);

        // R8: mask holds output high while flags still latch
        set_mode1(32'h2000_0000);
        err_pulse = 9'h001; stop_pulse = 1'b1; tick(); err_pulse = '0; stop_pulse = 1'b0;
        check(irq_n == 1'b1, "R8 masked irq_n", {31'b0, irq_n}, 1);
        check(stat_byte == 8'h14, "R8 flags latch under mask", {24'b0, stat_byte}, 32'h14);
        set_mode1(32'h0);
        check(irq_n == 1'b0, "R8 unmasked irq_n", {31'b0, irq_n}, 0);
        // R9: all three flags together
        evt_pulse = 14'h0001; tick(); evt_pulse = '0;
        check(stat_byte == 8'h34, "R9 status layout", {24'b0, stat_byte}, 32'h34);

        // R10: copy beats host write, unknown opcode inert
        buf_wr = 1'b1; buf_wdata = 32'hDEAD_BEEF; cmd_vld = 1'b1; cmd_op = 8'hF2; tick();
        buf_wr = 1'b0; cmd_vld = 1'b0;
        check(buf_rdata == 32'h001, "R10 copy priority", buf_rdata, 32'h1);
        load_buf(32'h1234_5678);
        check(buf_rdata == 32'h1234_5678, "R10 host write", buf_rdata, 32'h1234_5678);
        cmd(8'h55);
        check(buf_rdata == 32'h1234_5678, "R10 unknown opcode buffer", buf_rdata, 32'h1234_5678);
        check(stat_byte == 8'h24, "R10 unknown opcode flags", {24'b0, stat_byte}, 32'h24);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule